// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense and Mask

This block turns the sampled levels of a 16-pin general-purpose port into interrupt requests. Each pin has its own sense configuration: a level mode with a selectable active level, a single-edge mode with a selectable direction, and a mode that fires on any transition. A pin takes part only when it is configured as an input and its input enable is set. Every other pin keeps its stored data bit and its interrupt state no matter what its incoming level does.

A one-cycle sample strobe marks each new set of already-synchronized pin levels. On that strobe each participating pin copies its level into its data bit. The old data bit is the reference for edge detection. Edge events raise the pin's pending bit for exactly one cycle. Level events hold the pending bit for as long as the last sample is active. Two registered request outputs each OR together the pending bits selected by their own mask. They follow any mask change on the next clock even when no pin moves. Register access and synchronizers sit outside the block.

Top module: `gpio_irq_sense`

## Requirements
- R1: A pin i is sampled only in a cycle with sample_valid_i=1, dir_i[i]=0 and inen_i[i]=1. Otherwise its bits in data_o and its level-mode bit in pend_o do not change.
- R2: A sampled pin writes its level pin_level_i[i] into data_o[i] at the next clock edge. The previous data_o[i] is the old level used for edge detection.
- R3: With edge_i[i]=1 and both_i[i]=1, a sample whose level differs from the old level sets pend_o[i]. A sample with an equal level does not.
- R4: With edge_i[i]=1 and both_i[i]=0, polar_i[i]=0 fires on an old 0 / new 1 sample and polar_i[i]=1 fires on an old 1 / new 0 sample. No other sample fires.
- R5: An edge-mode pend_o[i] is high for exactly the one cycle after the firing sample. It returns to 0 in any cycle without a firing sample.
- R6: With edge_i[i]=0, a sample sets pend_o[i] to pin_level_i[i] XOR polar_i[i] (polar 0 is active high, polar 1 is active low). The bit holds that value until the next sample of that pin.
- R7: irq_a_o is the registered OR of pend_o AND mask_a_i, and irq_b_o is the same using mask_b_i. Both appear one clock after the pending state they reflect.
- R8: A change of mask_a_i or mask_b_i with no pin sample changes irq_a_o / irq_b_o at the next clock edge.
- R9: Changing edge_i, both_i or polar_i without a sample, or sampling an unchanged level, produces no edge-mode pending bit.
- R10: After rst_ni is asserted (low), data_o, pend_o, irq_a_o and irq_b_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe marking a new pin sample |
| pin_level_i | input | 16 | Synchronized pin levels, bit i is pin i |
| dir_i | input | 16 | 1 = pin is an output (not sampled) |
| inen_i | input | 16 | 1 = input enabled |
| edge_i | input | 16 | 1 = edge sensed, 0 = level sensed |
| both_i | input | 16 | 1 = any edge fires (edge mode only) |
| polar_i | input | 16 | Edge mode: 1 falling, 0 rising. Level mode: 1 active low |
| mask_a_i | input | 16 | Pin selection for irq_a_o |
| mask_b_i | input | 16 | Pin selection for irq_b_o |
| data_o | output | 16 | Stored sampled levels |
| pend_o | output | 16 | Per-pin interrupt pending state |
| irq_a_o | output | 1 | Masked interrupt request A |
| irq_b_o | output | 1 | Masked interrupt request B |

## Verification
On every cycle the assertions check the sample gating, the copying of the level into the data bit, the level-mode pending value, the clearing of edge pending bits outside firing samples, any-edge firing, and the one-cycle lag of both masked requests. Two things are shown only by the bench's scenarios. The first is the absence of spurious events when sense configuration changes, including the polarity rules of single-edge mode. The second is the exhaustive sweep over every per-pin configuration and old/new level pair, which is checked against an arithmetic model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DEF_PINS = 16;

  typedef struct packed {
    logic is_out;
    logic in_en;
    logic edge_mode;
    logic any_edge;
    logic invert;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     strobe_i,
  input  logic     level_i,
  input  pin_cfg_t cfg_i,
  output logic     data_o,
  output logic     pend_o
);
  logic take, hit;

  assign take = strobe_i & ~cfg_i.is_out & cfg_i.in_en;

  // old level is the stored data bit
  always_comb begin
    if (cfg_i.any_edge) hit = data_o ^ level_i;
    else if (cfg_i.invert) hit = data_o & ~level_i;
    else hit = ~data_o & level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (take) data_o <= level_i;
      if (cfg_i.edge_mode) pend_o <= take & hit;
      else if (take) pend_o <= level_i ^ cfg_i.invert;
    end
  end
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic                irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else irq_o <= |(pend_i & mask_i);
  end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = DEF_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [NUM_PINS-1:0] pin_level_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] inen_i,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] polar_i,
  input  logic [NUM_PINS-1:0] mask_a_i,
  input  logic [NUM_PINS-1:0] mask_b_i,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_a_o,
  output logic                irq_b_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{is_out: dir_i[i], in_en: inen_i[i], edge_mode: edge_i[i],
                   any_edge: both_i[i], invert: polar_i[i]};
    gpio_pin_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (sample_valid_i),
      .level_i  (pin_level_i[i]),
      .cfg_i    (cfg),
      .data_o   (data_o[i]),
      .pend_o   (pend_o[i])
    );
  end

  gpio_irq_combine #(.NUM_PINS(NUM_PINS)) u_irq_a (
    .clk_i (clk_i), .rst_ni (rst_ni), .pend_i (pend_o), .mask_i (mask_a_i), .irq_o (irq_a_o)
  );
  gpio_irq_combine #(.NUM_PINS(NUM_PINS)) u_irq_b (
    .clk_i (clk_i), .rst_ni (rst_ni), .pend_i (pend_o), .mask_i (mask_b_i), .irq_o (irq_b_o)
  );
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_valid_i,
  input logic [NUM_PINS-1:0] pin_level_i,
  input logic [NUM_PINS-1:0] dir_i,
  input logic [NUM_PINS-1:0] inen_i,
  input logic [NUM_PINS-1:0] edge_i,
  input logic [NUM_PINS-1:0] both_i,
  input logic [NUM_PINS-1:0] polar_i,
  input logic [NUM_PINS-1:0] mask_a_i,
  input logic [NUM_PINS-1:0] mask_b_i,
  input logic [NUM_PINS-1:0] data_o,
  input logic [NUM_PINS-1:0] pend_o,
  input logic                irq_a_o,
  input logic                irq_b_o
);
  logic [NUM_PINS-1:0] smask;
  assign smask = sample_valid_i ? (~dir_i & inen_i) : '0;

  assert_ignore_unsampled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((data_o ^ $past(data_o)) & ~$past(smask)) == '0);

  assert_level_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o ^ $past(pend_o)) & ~$past(smask) & ~$past(edge_i)) == '0);

  assert_data_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((data_o ^ $past(pin_level_i)) & $past(smask)) == '0);

  assert_any_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~pend_o & $past(smask & edge_i & both_i & (pin_level_i ^ data_o))) == '0);

  assert_edge_transient_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_o & $past(edge_i & ~smask)) == '0);

  assert_level_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o ^ $past(pin_level_i ^ polar_i)) & $past(smask & ~edge_i)) == '0);

  assert_irq_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_a_o == $past(|(pend_o & mask_a_i)));

  assert_irq_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_b_o == $past(|(pend_o & mask_b_i)));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_irq_sense_test.sv
module gpio_irq_sense_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sv = 1'b0;
  logic [N-1:0] lvl = '0, dir = '0, inen = '0, edg = '0, both = '0, pol = '0, ma = '0, mb = '0;
  logic [N-1:0] data_o, pend_o;
  logic irq_a_o, irq_b_o;

  logic [N-1:0] m_data = '0, m_pend = '0;
  logic m_irq_a = 1'b0, m_irq_b = 1'b0;
  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_sense #(.NUM_PINS(N)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .sample_valid_i (sv), .pin_level_i (lvl),
    .dir_i (dir), .inen_i (inen), .edge_i (edg), .both_i (both), .polar_i (pol),
    .mask_a_i (ma), .mask_b_i (mb), .data_o (data_o), .pend_o (pend_o),
    .irq_a_o (irq_a_o), .irq_b_o (irq_b_o)
  );

  task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // arithmetic model applied at each rising edge
  task automatic model_step();
    logic [N-1:0] nd, np;
    m_irq_a = |(m_pend & ma);
    m_irq_b = |(m_pend & mb);
    nd = m_data;
    np = m_pend;
    for (int i = 0; i < N; i++) begin
      logic g, o, n, ev;
      g = sv & ~dir[i] & inen[i];
      o = m_data[i];
      n = lvl[i];
      if (both[i]) ev = (o != n);
      else if (pol[i]) ev = (o == 1'b1) && (n == 1'b0);
      else ev = (o == 1'b0) && (n == 1'b1);
      if (edg[i]) np[i] = g & ev;
      else if (g) np[i] = (n != pol[i]);
      if (g) nd[i] = n;
    end
    m_data = nd;
    m_pend = np;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, "data", data_o, m_data);
    check(tag, "pend", pend_o, m_pend);
    check(tag, "irq_a", {15'd0, irq_a_o}, {15'd0, m_irq_a});
    check(tag, "irq_b", {15'd0, irq_b_o}, {15'd0, m_irq_b});
  endtask

  task automatic sample(input logic [N-1:0] l, input string tag);
    lvl = l; sv = 1'b1;
    tick(tag);
    sv = 1'b0;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "data", data_o, '0);
    check("R10", "pend", pend_o, '0);
    check("R10", "irqs", {14'd0, irq_a_o, irq_b_o}, '0);
    rst_ni = 1'b1;
    ma = 16'hFFFF; mb = 16'h00FF;

    // R1: outputs and disabled inputs ignore the pin
    dir = 16'h00F0; inen = 16'hFF0F;
    sample(16'hFFFF, "R1");
    sample(16'h0000, "R1");
    sample(16'h5A5A, "R1");

    // R2 and R6: level sensing with mixed polarity
    dir = '0; inen = '1; edg = '0; pol = 16'hF0F0;
    sample(16'h1234, "R2");
    sample(16'hFFFF, "R6");
    sample(16'h0000, "R6");
    lvl = 16'hAAAA; tick("R6");  // no strobe: hold
    tick("R6");

    // R3: any edge
    edg = '1; both = '1; pol = '0;
    sample(16'h0000, "R3");
    sample(16'hF00F, "R3");
    sample(16'hF00F, "R3");
    sample(16'h0FF0, "R3");

    // R4 and R5: single edge, rising on low byte, falling on high byte
    both = '0; pol = 16'hFF00;
    sample(16'h0000, "R4");
    sample(16'hFFFF, "R4");
    sample(16'h0000, "R4");
    lvl = 16'hFFFF; sv = 1'b1; tick("R5");
    sv = 1'b0; tick("R5"); tick("R5");

    // R9: config change alone does not fire
    pol = 16'h00FF; tick("R9");
    both = '1; tick("R9");
    edg = '0; tick("R9");
    edg = '1; tick("R9");
    sample(16'hFFFF, "R9");

    // R7 and R8: hold level pending, move masks only
    edg = '0; pol = '0; both = '0;
    sample(16'h0100, "R7");
    ma = 16'h0100; mb = 16'h0000; tick("R8"); tick("R8");
    ma = 16'h0000; mb = 16'h0100; tick("R8"); tick("R8");
    ma = 16'hFEFF; mb = 16'hFEFF; tick("R7"); tick("R7");

    // sweep: every per-pin configuration against every level transition
    for (int r = 0; r < 32; r++) begin
      for (int i = 0; i < N; i++) begin
        logic [4:0] c;
        c = 5'((i + r) % 32);
        dir[i] = c[0]; inen[i] = c[1]; edg[i] = c[2]; both[i] = c[3]; pol[i] = c[4];
      end
      ma = 16'(16'h1357 << (r % 5)); mb = ~ma;
      sample(16'h0000, "R3");
      sample(16'hFFFF, "R4");
      sample(16'hFFFF, "R6");
      sample(16'h0000, "R4");
      sample(16'hA5A5, "R3");
      sample(16'h5A5A, "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule